// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits on the host side of a parallel NOR flash and turns one request into the full series of bus cycles the flash needs to change its contents. A requester asks for a word program, a sector erase, a block erase or a whole-array erase. The block then emits the unlock and command writes through a write port that uses a valid/acknowledge handshake. After the last write it watches the flash through a read port with the same handshake until the operation finishes, and reports either success or failure.

Completion is detected in one of two ways, chosen for each request. In toggle mode the block looks for a status bit that stops alternating between two back-to-back reads. In data mode it waits for a status bit to show its true value. The flash finishes on its own schedule, so a read can catch a half-settled word. A word that seems wrong after completion is therefore read twice more before the operation is declared failed. A cycle budget for each kind of operation bounds the wait. On failure the block can send one reset-to-read write before it raises the error. Strobe timing and the flash itself are outside the block.

Top module: `nor_write_sequencer`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` is high and `busy` is low. `busy` rises on the next edge and stays high until the edge that pulses `done` or `error`. A request presented while `busy` is high has no effect: no extra bus cycle follows the current operation.
- R2: Operation code 0 (program) emits exactly four writes, in this order: 00AAh at 05555h, 0055h at 02AAAh, 00A0h at 05555h, then `req_data` at `req_addr`.
- R3: Operation codes 1 (sector), 2 (block) and 3 (whole array) emit six writes. The first five are 00AAh@05555h, 0055h@02AAAh, 0080h@05555h, 00AAh@05555h and 0055h@02AAAh. The sixth is 0030h at `req_addr` with its low SECTOR_W bits cleared, 0050h at `req_addr` with its low BLOCK_W bits cleared, or 0010h at 05555h.
- R4: Every status read goes to the address of the sixth write (erase) or of the fourth write (program). In toggle mode (`req_poll_mode`=0) the operation counts as settled only when two consecutive reads agree in bit 6. The first read never counts as settled.
- R5: In data mode (`req_poll_mode`=1) the operation counts as settled when bit 7 of a read equals bit 7 of the program data, or equals 1 for any erase.
- R6: When the settling read equals the expected word (the program data, or FFFFh for an erase), `done` pulses and no further read is issued.
- R7: When the settling read differs from the expected word, exactly two more reads of the same address follow. If both equal the expected word, `done` pulses. If one differs, the operation fails with `fail_timeout`=0, and no further read is issued.
- R8: If the operation has not settled within TMO_PROG (program), TMO_ERASE (sector/block) or TMO_CHIP (whole array) cycles of polling, it fails with `fail_timeout`=1.
- R9: With RESET_ON_ERR=1, a failure emits one write of 00F0h at address 0 before `error` pulses.
- R10: `done` and `error` are single-cycle pulses and never high together.
- R11: `wr_valid` and `rd_valid` are never high together. Each stays high, with its address (and write data) unchanged, until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 whole-array erase |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | DATA_W | Word to program |
| req_poll_mode | input | 1 | 0 toggle-bit polling, 1 data-bit polling |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Success pulse |
| error | output | 1 | Failure pulse |
| fail_timeout | output | 1 | Failure cause: 1 budget exhausted, 0 data mismatch |
| wr_valid | output | 1 | Bus write request |
| wr_addr | output | ADDR_W | Bus write address |
| wr_data | output | DATA_W | Bus write data |
| wr_ack | input | 1 | Bus write accepted |
| rd_valid | output | 1 | Bus read request |
| rd_addr | output | ADDR_W | Bus read address |
| rd_ack | input | 1 | Bus read complete, `rd_data` valid |
| rd_data | input | DATA_W | Bus read data |

## Verification
`busy` is due one edge after the accepting edge. The next write address appears on the same edge that consumes an acknowledge. `done` or `error` is registered one edge after the acknowledge of the read that decides the outcome, or after the acknowledge of the reset write. The bench drives all inputs and acknowledges on the falling edge and samples outputs there too, so each value is read half a cycle after the edge that produced it. Writes and reads are logged at the moment they are acknowledged, and the logs are compared with sequences and read counts worked out by hand from the flash model's scripted responses.

// File: rtl/nws_pkg.sv
package nws_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    EV_BUSY    = 2'd0,
    EV_GOOD    = 2'd1,
    EV_SUSPECT = 2'd2
  } verdict_e;

  localparam logic [14:0] UNLOCK_HI = 15'h5555;
  localparam logic [14:0] UNLOCK_LO = 15'h2AAA;
  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  CMD_WORD   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_BLK    = 8'h50;
  localparam logic [7:0]  CMD_ALL    = 8'h10;
  localparam logic [7:0]  CMD_RESET  = 8'hF0;
endpackage

// File: rtl/nws_cmd_gen.sv
module nws_cmd_gen
  import nws_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int SECTOR_W = 11,
  parameter int BLOCK_W  = 15
) (
  input  op_e               op,
  input  logic [ADDR_W-1:0] target,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        idx,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_data,
  output logic [2:0]        last_idx,
  output logic [ADDR_W-1:0] poll_addr
);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(UNLOCK_HI);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(UNLOCK_LO);
  localparam logic [ADDR_W-1:0] SECT_MASK = ~((ADDR_W'(1) << SECTOR_W) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] BLK_MASK  = ~((ADDR_W'(1) << BLOCK_W) - ADDR_W'(1));

  logic              is_prog;
  logic [ADDR_W-1:0] final_addr;
  logic [DATA_W-1:0] final_data;

  assign is_prog = (op == OP_PROG);

  // Address and code of the cycle that starts the internal operation.
  always_comb begin
    unique case (op)
      OP_PROG: begin final_addr = target;             final_data = wdata; end
      OP_SECT: begin final_addr = target & SECT_MASK; final_data = DATA_W'(CMD_SECT); end
      OP_BLK:  begin final_addr = target & BLK_MASK;  final_data = DATA_W'(CMD_BLK); end
      default: begin final_addr = A_HI;               final_data = DATA_W'(CMD_ALL); end
    endcase
  end

  always_comb begin
    cyc_addr = A_HI;
    cyc_data = DATA_W'(KEY_FIRST);
    unique case (idx)
      3'd0: begin cyc_addr = A_HI; cyc_data = DATA_W'(KEY_FIRST); end
      3'd1: begin cyc_addr = A_LO; cyc_data = DATA_W'(KEY_SECOND); end
      3'd2: begin
        cyc_addr = A_HI;
        cyc_data = is_prog ? DATA_W'(CMD_WORD) : DATA_W'(CMD_ERASE);
      end
      3'd3: begin
        cyc_addr = is_prog ? final_addr : A_HI;
        cyc_data = is_prog ? final_data : DATA_W'(KEY_FIRST);
      end
      3'd4: begin cyc_addr = A_LO; cyc_data = DATA_W'(KEY_SECOND); end
      3'd5: begin cyc_addr = final_addr; cyc_data = final_data; end
      default: begin cyc_addr = A_HI; cyc_data = DATA_W'(KEY_FIRST); end
    endcase
  end

  assign last_idx  = is_prog ? 3'd3 : 3'd5;
  assign poll_addr = final_addr;
endmodule

// File: rtl/nws_poll_eval.sv
module nws_poll_eval
  import nws_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TGL_BIT  = 6,
  parameter int POLL_BIT = 7
) (
  input  logic              data_mode,
  input  logic              have_prev,
  input  logic              prev_tgl,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [DATA_W-1:0] exp_word,
  output verdict_e          verdict
);
  logic settled;

  // Toggle mode: status bit frozen across two reads. Data mode: status bit true.
  always_comb begin
    if (data_mode) settled = (rd_word[POLL_BIT] == exp_word[POLL_BIT]);
    else           settled = have_prev && (rd_word[TGL_BIT] == prev_tgl);
  end

  always_comb begin
    if (!settled)                  verdict = EV_BUSY;
    else if (rd_word == exp_word)  verdict = EV_GOOD;
    else                           verdict = EV_SUSPECT;
  end
endmodule

// File: rtl/nws_timer.sv
module nws_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)          cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  // R8: the budget counter saturates at its limit.
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);
endmodule

// File: rtl/nor_write_sequencer.sv
module nor_write_sequencer
  import nws_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int SECTOR_W     = 11,
  parameter int BLOCK_W      = 15,
  parameter int TMO_PROG     = 4000,
  parameter int TMO_ERASE    = 2000000,
  parameter int TMO_CHIP     = 8000000,
  parameter bit RESET_ON_ERR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_poll_mode,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              fail_timeout,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int TMO_MAX = (TMO_PROG > TMO_ERASE) ?
                           ((TMO_PROG > TMO_CHIP) ? TMO_PROG : TMO_CHIP) :
                           ((TMO_ERASE > TMO_CHIP) ? TMO_ERASE : TMO_CHIP);
  localparam int TMO_W = $clog2(TMO_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_WRITE, S_POLL_GO, S_POLL_WAIT, S_CONF_GO, S_CONF_WAIT, S_RESET_WAIT
  } state_e;

  state_e            st;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              mode_q;
  logic [2:0]        idx;
  logic              have_prev;
  logic              prev_tgl;
  logic              conf_second;

  logic [2:0]        gen_idx;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] cyc_data;
  logic [2:0]        last_idx;
  logic [ADDR_W-1:0] poll_addr;
  logic [DATA_W-1:0] exp_word;
  verdict_e          verdict;
  logic [TMO_W-1:0]  tmo_limit;
  logic              polling;
  logic              tmo_expired;
  logic              fail_now;
  logic              pass_now;

  // While a write is being acknowledged, look ahead to the next cycle.
  assign gen_idx = (st == S_WRITE) ? idx + 3'd1 : idx;

  nws_cmd_gen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W)
  ) u_gen (
    .op(op_q), .target(addr_q), .wdata(data_q), .idx(gen_idx),
    .cyc_addr(cyc_addr), .cyc_data(cyc_data), .last_idx(last_idx), .poll_addr(poll_addr)
  );

  assign exp_word = (op_q == OP_PROG) ? data_q : '1;

  nws_poll_eval #(.DATA_W(DATA_W), .TGL_BIT(6), .POLL_BIT(7)) u_eval (
    .data_mode(mode_q), .have_prev(have_prev), .prev_tgl(prev_tgl),
    .rd_word(rd_data), .exp_word(exp_word), .verdict(verdict)
  );

  always_comb begin
    unique case (op_q)
      OP_PROG: tmo_limit = TMO_W'(TMO_PROG);
      OP_CHIP: tmo_limit = TMO_W'(TMO_CHIP);
      default: tmo_limit = TMO_W'(TMO_ERASE);
    endcase
  end

  assign polling = (st == S_POLL_GO) || (st == S_POLL_WAIT);

  nws_timer #(.W(TMO_W)) u_tmo (
    .clk(clk), .rst(rst), .clear(!polling), .run(polling),
    .limit(tmo_limit), .expired(tmo_expired)
  );

  assign fail_now = ((st == S_POLL_GO) && tmo_expired) ||
                    ((st == S_CONF_WAIT) && rd_ack && (rd_data != exp_word));
  assign pass_now = ((st == S_POLL_WAIT) && rd_ack && (verdict == EV_GOOD)) ||
                    ((st == S_CONF_WAIT) && rd_ack && (rd_data == exp_word) && conf_second);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      op_q         <= OP_PROG;
      addr_q       <= '0;
      data_q       <= '0;
      mode_q       <= 1'b0;
      idx          <= '0;
      have_prev    <= 1'b0;
      prev_tgl     <= 1'b0;
      conf_second  <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      error        <= 1'b0;
      fail_timeout <= 1'b0;
      wr_valid     <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      rd_valid     <= 1'b0;
      rd_addr      <= '0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          op_q         <= op_e'(req_op);
          addr_q       <= req_addr;
          data_q       <= req_data;
          mode_q       <= req_poll_mode;
          idx          <= '0;
          busy         <= 1'b1;
          fail_timeout <= 1'b0;
          st           <= S_LOAD;
        end
        S_LOAD: begin
          wr_valid <= 1'b1;
          wr_addr  <= cyc_addr;
          wr_data  <= cyc_data;
          st       <= S_WRITE;
        end
        S_WRITE: if (wr_ack) begin
          if (idx == last_idx) begin
            wr_valid  <= 1'b0;
            have_prev <= 1'b0;
            st        <= S_POLL_GO;
          end else begin
            idx     <= idx + 3'd1;
            wr_addr <= cyc_addr;
            wr_data <= cyc_data;
          end
        end
        S_POLL_GO: begin
          rd_valid <= 1'b1;
          rd_addr  <= poll_addr;
          st       <= S_POLL_WAIT;
        end
        S_POLL_WAIT: if (rd_ack) begin
          rd_valid  <= 1'b0;
          have_prev <= 1'b1;
          prev_tgl  <= rd_data[6];
          if (verdict == EV_SUSPECT) begin
            conf_second <= 1'b0;
            st          <= S_CONF_GO;
          end else begin
            st <= S_POLL_GO;
          end
        end
        S_CONF_GO: begin
          rd_valid <= 1'b1;
          st       <= S_CONF_WAIT;
        end
        S_CONF_WAIT: if (rd_ack) begin
          rd_valid    <= 1'b0;
          conf_second <= 1'b1;
          st          <= S_CONF_GO;
        end
        S_RESET_WAIT: if (wr_ack) begin
          wr_valid <= 1'b0;
          error    <= 1'b1;
          busy     <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase

      if (pass_now) begin
        rd_valid <= 1'b0;
        done     <= 1'b1;
        busy     <= 1'b0;
        st       <= S_IDLE;
      end

      if (fail_now) begin
        rd_valid     <= 1'b0;
        fail_timeout <= (st == S_POLL_GO);
        if (RESET_ON_ERR) begin
          wr_valid <= 1'b1;
          wr_addr  <= '0;
          wr_data  <= DATA_W'(CMD_RESET);
          st       <= S_RESET_WAIT;
        end else begin
          error <= 1'b1;
          busy  <= 1'b0;
          st    <= S_IDLE;
        end
      end
    end
  end

  // R11: one bus strobe at a time, each held steady until acknowledged.
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && rd_valid));
  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ack) |=> (rd_valid && $stable(rd_addr)));
  // R10: outcome pulses.
  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_error_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    error |=> !error);
  // R1: acceptance and busy span.
  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> busy);
  assert_strobe_needs_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_valid || rd_valid) |-> busy);
  assert_end_clears_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> !busy);
endmodule

// File: tb/nor_write_sequencer_test.sv
module nor_write_sequencer_test;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int T_PROG = 60;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_poll_mode = 1'b0;
  logic          busy, done, error, fail_timeout;
  logic          wr_valid, rd_valid;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic          wr_ack = 1'b0;
  logic          rd_ack = 1'b0;
  logic [DW-1:0] rd_data = '0;

  always #5 clk = ~clk;

  nor_write_sequencer #(
    .ADDR_W(AW), .DATA_W(DW), .SECTOR_W(11), .BLOCK_W(15),
    .TMO_PROG(T_PROG), .TMO_ERASE(150), .TMO_CHIP(300), .RESET_ON_ERR(1'b1)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_poll_mode(req_poll_mode),
    .busy(busy), .done(done), .error(error), .fail_timeout(fail_timeout),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  bit reported = 1'b0;

  // Flash model state
  logic [AW-1:0] wlog_a [16];
  logic [DW-1:0] wlog_d [16];
  int            wcount;
  int            rcount;
  logic [AW-1:0] exp_raddr;
  int            bad_raddr;
  int            busy_left;
  logic          busy_b7;
  logic          tgl;
  logic [DW-1:0] post_q [4];
  int            post_idx;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Bus responder: acknowledge one cycle after a strobe, on the falling edge.
  always @(negedge clk) begin
    if (wr_valid && !wr_ack) begin
      wr_ack = 1'b1;
      if (wcount < 16) begin
        wlog_a[wcount] = wr_addr;
        wlog_d[wcount] = wr_data;
      end
      wcount++;
    end else begin
      wr_ack = 1'b0;
    end
    if (rd_valid && !rd_ack) begin
      rd_ack = 1'b1;
      if (rd_addr != exp_raddr) bad_raddr++;
      rcount++;
      if (busy_left > 0) begin
        busy_left--;
        rd_data = {8'h00, busy_b7, tgl, 6'h15};
        tgl = ~tgl;
      end else begin
        rd_data = post_q[post_idx];
        if (post_idx < 3) post_idx++;
      end
    end else begin
      rd_ack = 1'b0;
    end
  end

  task automatic setup_model(input int nbusy, input logic b7, input logic [AW-1:0] raddr,
                             input logic [DW-1:0] p0, input logic [DW-1:0] p1,
                             input logic [DW-1:0] p2);
    wcount = 0; rcount = 0; bad_raddr = 0;
    busy_left = nbusy; busy_b7 = b7; tgl = 1'b0; exp_raddr = raddr;
    post_q[0] = p0; post_q[1] = p1; post_q[2] = p2; post_q[3] = p2; post_idx = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic mode);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_poll_mode = mode;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R1", "busy after accept", busy, 1);
  endtask

  bit got_done, got_err, got_cause;
  int elapsed;

  task automatic wait_end();
    got_done = 0; got_err = 0; got_cause = 0; elapsed = 0;
    while (!done && !error && elapsed < 5000) begin
      @(negedge clk);
      elapsed++;
    end
    got_done = done; got_err = error; got_cause = fail_timeout;
    check(!(done && error), "R10", "done and error together", {done, error}, 0);
    check(busy == 1'b0, "R1", "busy at outcome", busy, 0);
    @(negedge clk);
    check(!done && !error, "R10", "outcome pulse length", {done, error}, 0);
  endtask

  task automatic check_wr(input int i, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input string req);
    check(wlog_a[i] == a, req, $sformatf("write %0d addr", i), 32'(wlog_a[i]), 32'(a));
    check(wlog_d[i] == d, req, $sformatf("write %0d data", i), 32'(wlog_d[i]), 32'(d));
  endtask

  task automatic check_erase_head();
    check_wr(0, 18'h05555, 16'h00AA, "R3");
    check_wr(1, 18'h02AAA, 16'h0055, "R3");
    check_wr(2, 18'h05555, 16'h0080, "R3");
    check_wr(3, 18'h05555, 16'h00AA, "R3");
    check_wr(4, 18'h02AAA, 16'h0055, "R3");
  endtask

  // R2/R4/R6/R1: program, toggle mode, with a refused request while busy.
  task automatic t_program_toggle();
    setup_model(3, 1'b1, 18'h01234, 16'h1234, 16'h1234, 16'h1234);
    issue(2'd0, 18'h01234, 16'h1234, 1'b0);
    @(negedge clk); req_valid = 1'b1; req_op = 2'd3;
    @(negedge clk); req_valid = 1'b0;
    wait_end();
    check(got_done && !got_err, "R6", "program toggle outcome", {got_done, got_err}, 2'b10);
    check(wcount == 4, "R2", "program write count", wcount, 4);
    check_wr(0, 18'h05555, 16'h00AA, "R2");
    check_wr(1, 18'h02AAA, 16'h0055, "R2");
    check_wr(2, 18'h05555, 16'h00A0, "R2");
    check_wr(3, 18'h01234, 16'h1234, "R2");
    check(rcount == 4, "R4", "toggle read count", rcount, 4);
    check(bad_raddr == 0, "R4", "read address", bad_raddr, 0);
    repeat (10) @(negedge clk);
    check(!busy && wcount == 4, "R1", "request during busy ignored", wcount, 4);
  endtask

  // R3/R5: sector erase, data mode.
  task automatic t_sector_data();
    setup_model(4, 1'b0, 18'h12000, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    issue(2'd1, 18'h12345, 16'h0000, 1'b1);
    wait_end();
    check(got_done && !got_err, "R5", "sector outcome", {got_done, got_err}, 2'b10);
    check(wcount == 6, "R3", "sector write count", wcount, 6);
    check_erase_head();
    check_wr(5, 18'h12000, 16'h0030, "R3");
    check(rcount == 5, "R5", "data-mode read count", rcount, 5);
    check(bad_raddr == 0, "R4", "sector read address", bad_raddr, 0);
  endtask

  // R3/R4: block erase, toggle mode.
  task automatic t_block_toggle();
    setup_model(2, 1'b0, 18'h28000, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    issue(2'd2, 18'h2ABCD, 16'h0000, 1'b0);
    wait_end();
    check(got_done && !got_err, "R4", "block outcome", {got_done, got_err}, 2'b10);
    check(wcount == 6, "R3", "block write count", wcount, 6);
    check_wr(5, 18'h28000, 16'h0050, "R3");
    check(rcount == 3, "R4", "block read count", rcount, 3);
  endtask

  // R3/R5: whole-array erase, data mode.
  task automatic t_chip_data();
    setup_model(1, 1'b0, 18'h05555, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    issue(2'd3, 18'h3FFFF, 16'h0000, 1'b1);
    wait_end();
    check(got_done && !got_err, "R5", "chip outcome", {got_done, got_err}, 2'b10);
    check_erase_head();
    check_wr(5, 18'h05555, 16'h0010, "R3");
    check(rcount == 2, "R5", "chip read count", rcount, 2);
    check(bad_raddr == 0, "R4", "chip read address", bad_raddr, 0);
  endtask

  // R7: suspect word, both re-reads agree -> success.
  task automatic t_race_recovers();
    setup_model(2, 1'b0, 18'h00100, 16'h0083, 16'h00C3, 16'h00C3);
    issue(2'd0, 18'h00100, 16'h00C3, 1'b1);
    wait_end();
    check(got_done && !got_err, "R7", "re-read recovery", {got_done, got_err}, 2'b10);
    check(rcount == 5, "R7", "re-read count", rcount, 5);
    check(wcount == 4, "R7", "no reset write on success", wcount, 4);
  endtask

  // R7/R9: second re-read disagrees -> failure with reset write.
  task automatic t_race_fails();
    setup_model(2, 1'b0, 18'h00100, 16'h0083, 16'h00C3, 16'h0041);
    issue(2'd0, 18'h00100, 16'h00C3, 1'b1);
    wait_end();
    check(got_err && !got_done, "R7", "mismatch outcome", {got_done, got_err}, 2'b01);
    check(got_cause == 1'b0, "R7", "mismatch cause", got_cause, 0);
    check(rcount == 5, "R7", "mismatch read count", rcount, 5);
    check(wcount == 5, "R9", "write count with reset", wcount, 5);
    check_wr(4, 18'h00000, 16'h00F0, "R9");
  endtask

  // R8/R9: flash never settles.
  task automatic t_timeout();
    setup_model(1000000, 1'b1, 18'h00ABC, 16'h5A5A, 16'h5A5A, 16'h5A5A);
    issue(2'd0, 18'h00ABC, 16'h5A5A, 1'b0);
    wait_end();
    check(got_err && !got_done, "R8", "timeout outcome", {got_done, got_err}, 2'b01);
    check(got_cause == 1'b1, "R8", "timeout cause", got_cause, 1);
    check(elapsed >= T_PROG, "R8", "timeout not early", elapsed, T_PROG);
    check(wcount == 5, "R9", "timeout reset write count", wcount, 5);
    check_wr(4, 18'h00000, 16'h00F0, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual expired expected finish");
    report();
  end

  initial begin
    wcount = 0; rcount = 0; bad_raddr = 0; busy_left = 0; post_idx = 0;
    exp_raddr = '0; busy_b7 = 1'b0; tgl = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !error, "R1", "reset outcome state", {busy, done, error}, 0);
    check(!wr_valid && !rd_valid, "R11", "reset strobes", {wr_valid, rd_valid}, 0);
    t_program_toggle();
    t_sector_data();
    t_block_toggle();
    t_chip_data();
    t_race_recovers();
    t_race_fails();
    t_timeout();
    report();
  end
endmodule